// File: doc/BRIEF.md
# Oversampled Majority-Vote Serial Receiver

This block recovers bytes from an asynchronous serial line, one channel at a time. The frame is one start bit (low), eight data bits sent least significant bit first, and one stop bit (high). The line idles high. A separate sampler and baud tick, both outside the block, take five samples of the line in each nominal bit period. They hand the block one packed 5-bit group per bit time, strobed by `grp_valid_i`. `grp_i[0]` is the earliest sample in the group and `grp_i[4]` the latest.

The block keeps the previous group, so it sees a ten-sample window. It finds the high-to-low edge that opens a start bit and remembers where in the group that edge fell. It then reads every later bit from the five samples that follow that alignment, taking the majority of the middle three. A stop bit that ends one sample early does not lose the next frame. The next start edge is looked for in the same group that decides the stop bit, so a sender running slightly fast is tracked by slipping the alignment.

A finished byte goes into a single holding register, together with a framing-error flag. A one-cycle pulse marks its arrival. The consumer has until the next byte completes to read it, and acknowledges the read with `rx_read_i`.

Top module: `ovs_uart_rx`

## Requirements
- R1: After reset, `rx_valid_o`, `rx_frame_err_o` and `rx_overrun_o` are 0 and `rx_data_o` is 0x00.
- R2: Only cycles with `grp_valid_i` high advance the receiver. The value on `grp_i` in other cycles has no effect on any delivered byte.
- R3: A start is a sample at 0 whose preceding sample is 1, and that sample is the first of the start bit. If the majority of samples 2 to 4 of the start bit is 1, the start is a glitch and no byte is delivered.
- R4: Each data bit takes the majority of its 2nd, 3rd and 4th samples. Flipping its 1st and 5th samples does not change the received byte.
- R5: Data bits are assembled LSB first into `rx_data_o`. `rx_valid_o` is high for exactly one clock: the clock after the `grp_valid_i` cycle whose group completes the stop bit.
- R6: If the majority of the stop bit's middle samples is 0, the byte is still delivered, with `rx_frame_err_o`=1. With a good stop bit, `rx_frame_err_o`=0.
- R7: A stop bit only four samples long, followed at once by the next start bit, still gives both frames correctly. This holds for every alignment.
- R8: Back-to-back frames with a full-length stop bit and no idle time are all received.
- R9: `rx_data_o` and `rx_frame_err_o` hold their value until the next byte completes.
- R10: If a byte completes while the previous one is unread and `rx_read_i` is low in that cycle, `rx_overrun_o` goes to 1 and the new byte replaces the old one. `rx_read_i` without a completion clears `rx_overrun_o` on the next clock.
- R11: After a framing error the receiver waits for a fresh high-to-low edge. A line held low (break) produces no further bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| grp_valid_i | input | 1 | One pulse per bit time; `grp_i` is valid |
| grp_i | input | OSR (5) | Packed line samples, bit 0 earliest |
| rx_read_i | input | 1 | Consumer has taken the held byte |
| rx_valid_o | output | 1 | One-cycle pulse: new byte in holding register |
| rx_data_o | output | DATA_W (8) | Held byte |
| rx_frame_err_o | output | 1 | Held byte had a low stop bit |
| rx_overrun_o | output | 1 | An unread byte was overwritten |

## Verification
A wrong alignment offset or bit counter has no effect until the stop bit is decided. It then shows at the ports within one frame, about eleven bit times: a shifted or rotated byte, a false framing flag, or a missing or extra `rx_valid_o` pulse. Slip errors appear only when a frame starts in the group that decides the previous stop. Runs of back-to-back four-sample stops are therefore used to rotate the alignment through all five values. Errors in the holding logic show the very next clock as a wrong overrun level, or as data that moves with no valid pulse.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/ovs_win_vote.sv
// Majority of the three centre samples of a bit starting at offs_i in the window.
module ovs_win_vote #(
  parameter int OSR = 5
) (
  input  logic [2*OSR-1:0]         win_i,
  input  logic [$clog2(OSR)-1:0]   offs_i,
  output logic                     bit_o
);
  localparam int W     = 2 * OSR;
  localparam int IDX_W = $clog2(W);
  localparam int MID   = OSR / 2;

  logic [2:0] tap;

  for (genvar i = 0; i < 3; i++) begin : g_tap
    assign tap[i] = win_i[IDX_W'(offs_i) + IDX_W'(MID - 1 + i)];
  end

  assign bit_o = (tap[0] & tap[1]) | (tap[0] & tap[2]) | (tap[1] & tap[2]);
endmodule

// File: rtl/ovs_edge_find.sv
// Lowest window position at or above min_i with a 1->0 transition.
module ovs_edge_find #(
  parameter int OSR = 5
) (
  input  logic [2*OSR-1:0]          win_i,
  input  logic [$clog2(2*OSR)-1:0]  min_i,
  output logic                      found_o,
  output logic [$clog2(2*OSR)-1:0]  pos_o
);
  localparam int W     = 2 * OSR;
  localparam int IDX_W = $clog2(W);

  logic [W-1:1] edge_v;

  for (genvar p = 1; p < W; p++) begin : g_edge
    assign edge_v[p] = !win_i[p] && win_i[p-1] && (IDX_W'(p) >= min_i);
  end

  always_comb begin
    found_o = 1'b0;
    pos_o   = '0;
    for (int p = W - 1; p >= 1; p--) begin
      if (edge_v[p]) begin
        found_o = 1'b1;
        pos_o   = IDX_W'(p);
      end
    end
  end
endmodule

// File: rtl/ovs_rx_fsm.sv
module ovs_rx_fsm
  import ovs_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grp_valid_i,
  input  logic [OSR-1:0]    grp_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ferr_o
);
  localparam int W     = 2 * OSR;
  localparam int OFF_W = $clog2(OSR);
  localparam int IDX_W = $clog2(W);
  localparam int CNT_W = $clog2(DATA_W);

  rx_state_e         state_q, state_d;
  logic [OFF_W-1:0]  offs_q, offs_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic [OSR-1:0]    prev_q;

  logic [W-1:0]      win;
  logic              bit_v, slip_start_v;
  logic              edge_found;
  logic [IDX_W-1:0]  edge_pos, min_idx;

  assign win = {grp_i, prev_q};

  ovs_win_vote #(.OSR(OSR)) u_vote (
    .win_i (win),
    .offs_i(offs_q),
    .bit_o (bit_v)
  );

  // Start bit already begun in the previous group (only reachable from offset 0).
  ovs_win_vote #(.OSR(OSR)) u_vote_slip (
    .win_i (win),
    .offs_i(edge_pos[OFF_W-1:0]),
    .bit_o (slip_start_v)
  );

  assign min_idx = (state_q == ST_STOP) ? IDX_W'(offs_q) + IDX_W'(OSR - 1) : IDX_W'(OSR);

  ovs_edge_find #(.OSR(OSR)) u_edge (
    .win_i  (win),
    .min_i  (min_idx),
    .found_o(edge_found),
    .pos_o  (edge_pos)
  );

  always_comb begin
    state_d = state_q;
    offs_d  = offs_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    if (grp_valid_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (edge_found) begin
            offs_d  = OFF_W'(edge_pos - IDX_W'(OSR));
            state_d = ST_START;
          end
        end
        ST_START: begin
          cnt_d   = '0;
          state_d = bit_v ? ST_IDLE : ST_DATA;
        end
        ST_DATA: begin
          shift_d = {bit_v, shift_q[DATA_W-1:1]};
          cnt_d   = cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(DATA_W - 1)) state_d = ST_STOP;
        end
        ST_STOP: begin
          state_d = ST_IDLE;
          if (bit_v && edge_found) begin
            if (edge_pos >= IDX_W'(OSR)) begin
              offs_d  = OFF_W'(edge_pos - IDX_W'(OSR));
              state_d = ST_START;
            end else begin
              offs_d  = edge_pos[OFF_W-1:0];
              cnt_d   = '0;
              state_d = slip_start_v ? ST_IDLE : ST_DATA;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      offs_q  <= '0;
      cnt_q   <= '0;
      shift_q <= '0;
      prev_q  <= '1;
    end else begin
      state_q <= state_d;
      offs_q  <= offs_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      if (grp_valid_i) prev_q <= grp_i;
    end
  end

  assign done_o = grp_valid_i && (state_q == ST_STOP);
  assign data_o = shift_q;
  assign ferr_o = !bit_v;

  AST_GRP_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grp_valid_i |=> $stable(state_q) && $stable(shift_q) && $stable(offs_q)); // R2
  AST_IDLE_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && grp_valid_i && (grp_i == '1) |=> state_q == ST_IDLE); // R3
endmodule

// File: rtl/ovs_rx_hold.sv
module ovs_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ferr_i,
  input  logic              read_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ferr_o,
  output logic              ovr_o
);
  logic full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      ferr_o  <= 1'b0;
      ovr_o   <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      valid_o <= done_i;
      full_q  <= done_i | (full_q & ~read_i);
      if (done_i) begin
        data_o <= data_i;
        ferr_o <= ferr_i;
        ovr_o  <= full_q & ~read_i;
      end else if (read_i) begin
        ovr_o  <= 1'b0;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(data_o) && $stable(ferr_o)); // R9
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && full_q && !read_i |=> ovr_o); // R10
  AST_READ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_i && !done_i |=> !ovr_o); // R10
endmodule

// File: rtl/ovs_uart_rx.sv
module ovs_uart_rx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              grp_valid_i,
  input  logic [OSR-1:0]    grp_i,
  input  logic              rx_read_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_frame_err_o,
  output logic              rx_overrun_o
);
  logic              done;
  logic [DATA_W-1:0] data;
  logic              ferr;

  ovs_rx_fsm #(.DATA_W(DATA_W), .OSR(OSR)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grp_valid_i(grp_valid_i),
    .grp_i      (grp_i),
    .done_o     (done),
    .data_o     (data),
    .ferr_o     (ferr)
  );

  ovs_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (done),
    .data_i (data),
    .ferr_i (ferr),
    .read_i (rx_read_i),
    .valid_o(rx_valid_o),
    .data_o (rx_data_o),
    .ferr_o (rx_frame_err_o),
    .ovr_o  (rx_overrun_o)
  );
endmodule

// File: tb/ovs_uart_rx_tb_top.sv
`timescale 1ns/1ps
module ovs_uart_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       grp_valid = 1'b0;
  logic [4:0] grp = 5'h1f;
  logic       rx_read = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_ferr;
  logic       rx_ovr;

  int checks = 0;
  int errors = 0;
  bit line_q[$];
  logic [8:0] exp_q[$];
  string cur_req = "R1";
  bit auto_read = 1'b1;
  bit pending = 1'b0;

  always #2.5 clk = ~clk;

  ovs_uart_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .grp_valid_i(grp_valid), .grp_i(grp),
    .rx_read_i(rx_read), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .rx_frame_err_o(rx_ferr), .rx_overrun_o(rx_ovr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_n(input bit v, input int n);
    for (int i = 0; i < n; i++) line_q.push_back(v);
  endtask

  task automatic push_frame(input logic [7:0] b, input int stop_len, input bit stop_ok, input bit noisy);
    push_n(1'b0, 5);
    for (int i = 0; i < 8; i++) begin
      if (noisy) begin
        line_q.push_back(!b[i]); push_n(b[i], 3); line_q.push_back(!b[i]);
      end else push_n(b[i], 5);
    end
    if (stop_ok) push_n(1'b1, stop_len); else push_n(1'b0, 5);
    exp_q.push_back({!stop_ok, b});
  endtask

  task automatic check_out();
    logic [8:0] e;
    bit exp_ovr;
    if (rx_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, {cur_req, "/R3 unexpected byte"}, {23'd0, rx_ferr, rx_data}, 32'h0);
      end else begin
        e = exp_q.pop_front();
        chk(rx_data == e[7:0], {cur_req, "/R5 data"}, rx_data, e[7:0]);
        chk(rx_ferr == e[8], {cur_req, "/R6 frame_err"}, rx_ferr, e[8]);
      end
      exp_ovr = pending;
      pending = 1'b1;
      chk(rx_ovr == exp_ovr, "R10 overrun on completion", rx_ovr, exp_ovr);
      if (auto_read) begin
        rx_read = 1'b1;
        @(negedge clk);
        rx_read = 1'b0;
        pending = 1'b0;
        chk(rx_valid == 1'b0, "R5 valid one cycle", rx_valid, 0);
        chk(rx_ovr == 1'b0, "R10 read clears overrun", rx_ovr, 0);
      end
    end
  endtask

  task automatic feed_all();
    logic [4:0] g;
    while (line_q.size() % 5 != 0) line_q.push_back(1'b1);
    push_n(1'b1, 15);
    while (line_q.size() >= 5) begin
      for (int i = 0; i < 5; i++) g[i] = line_q.pop_front();
      @(negedge clk);
      grp_valid = 1'b1;
      grp = g;
      @(negedge clk);
      grp_valid = 1'b0;
      grp = 5'($urandom);  // R2: garbage while strobe low
      check_out();
      for (int i = 0; i < int'($urandom % 3); i++) @(negedge clk);
    end
  endtask

  task automatic section_done(input string req);
    chk(exp_q.size() == 0, {req, " all bytes delivered"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_valid == 0 && rx_ferr == 0 && rx_ovr == 0 && rx_data == 8'h00, "R1 reset state",
        {rx_valid, rx_ferr, rx_ovr, rx_data}, 0);

    cur_req = "R5";
    push_n(1'b1, 7); push_frame(8'hA5, 5, 1, 0); feed_all(); section_done("R5");

    cur_req = "R3";
    push_n(1'b1, 6); push_n(1'b0, 1); push_n(1'b1, 12);
    push_n(1'b0, 2); push_n(1'b1, 12);
    push_frame(8'h3C, 5, 1, 0); feed_all(); section_done("R3");

    cur_req = "R4";
    push_n(1'b1, 3); push_frame(8'h96, 5, 1, 1); push_n(1'b1, 4);
    push_frame(8'h69, 5, 1, 1); feed_all(); section_done("R4");

    cur_req = "R6";
    push_n(1'b1, 2); push_frame(8'hC3, 5, 0, 0); push_n(1'b1, 12);
    push_frame(8'h81, 5, 1, 0); feed_all(); section_done("R6");

    cur_req = "R11";
    push_n(1'b1, 4); push_frame(8'h00, 5, 0, 0); push_n(1'b0, 30); push_n(1'b1, 12);
    push_frame(8'h5A, 5, 1, 0); feed_all(); section_done("R11");

    cur_req = "R8";
    push_n(1'b1, 1);
    for (int i = 0; i < 4; i++) push_frame(8'(8'h11 * (i + 3)), 5, 1, 0);
    feed_all(); section_done("R8");

    cur_req = "R7";
    push_n(1'b1, 8);
    for (int i = 0; i < 7; i++) push_frame(8'(8'h27 + 8'h31 * i), 4, 1, 0);
    feed_all(); section_done("R7");

    cur_req = "R10";
    auto_read = 1'b0;
    push_n(1'b1, 3); push_frame(8'h11, 5, 1, 0); push_n(1'b1, 9);
    push_frame(8'h22, 5, 1, 0); feed_all(); section_done("R10");
    chk(rx_ovr == 1'b1, "R10 overrun held", rx_ovr, 1);
    push_n(1'b1, 20); feed_all();
    chk(rx_data == 8'h22 && rx_ferr == 1'b0, "R9 holding stable", {rx_ferr, rx_data}, 9'h022);
    @(negedge clk); rx_read = 1'b1; @(negedge clk); rx_read = 1'b0; pending = 1'b0;
    chk(rx_ovr == 1'b0, "R10 read clears overrun", rx_ovr, 0);
    auto_read = 1'b1;

    cur_req = "R2";
    push_n(1'b1, 5);
    for (int f = 0; f < 60; f++) begin
      int kind = int'($urandom % 8);
      logic [7:0] b = 8'($urandom);
      if (kind == 0) begin
        push_frame(b, 5, 0, 0); push_n(1'b1, 12);
      end else if (kind <= 2) begin
        push_frame(b, 4, 1, 0);
      end else begin
        push_frame(b, 5, 1, kind == 7); push_n(1'b1, int'($urandom % 6));
      end
    end
    feed_all(); section_done("R2");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule